// File: doc/BRIEF.md
# SPI Master Chip-Select and Mode-Fault Controller

This block owns the chip-select line of an SPI controller when the controller acts as a master. It keeps the controller's enable and master-mode state bits. It decides whether the select pin is driven and what level it carries. It also watches the pin for another master that claims the bus. Select is active-low. Software loads the enable and master bits through a one-cycle write strobe. A neighbouring shift engine reports the start and end of each frame with single-cycle strobes, plus a level that says another frame is already queued.

Select can be generated in hardware or taken from a software level. Under hardware control there are two framing policies. In the per-frame policy, select goes inactive after every frame. In the held policy, select stays asserted across queued frames and is released only after the last one. The pin is driven only while the controller is enabled, in master mode, and configured to drive select. In every other case the pin is an input.

When the pin is an input in master mode and another device pulls it low, the block records a sticky fault. In the same update it clears its own enable and master bits, which releases the pin. Software must clear the fault with a one-cycle clear strobe and write the enable and master bits again. The block never turns itself back on.

Top module: `spisel_ctrl`

## Requirements
- R1: After reset, `ctl_enable`, `ctl_master`, `fault_flag` and `sel_pin_oe` are 0, and `sel_pin_o` is 1 (inactive).
- R2: A cycle with `ctl_wr` high loads `ctl_wr_enable` into `ctl_enable` and `ctl_wr_master` into `ctl_master`, visible after that clock edge, unless a fault is detected in the same cycle.
- R3: When `ctl_master` is 1, `sel_oe_cfg` is 0 and `sel_pin_i` has been 0 for two clock edges (the synchronizer depth), the next edge sets `fault_flag` and clears `ctl_enable`, `ctl_master` and `sel_pin_oe`. The total latency from the pin going low to these outputs changing is three rising edges.
- R4: A low on `sel_pin_i` causes no fault when `sel_oe_cfg` is 1 or when `ctl_master` is 0.
- R5: `sel_pin_oe` is 1 only when `ctl_enable`, `ctl_master` and `sel_oe_cfg` are all 1. In slave mode it is 0 whatever `sel_oe_cfg` holds, and `sel_pin_o` is then 1.
- R6: `fault_flag` stays set until a cycle with `fault_clr` high. If a new fault is detected in that same cycle, the flag stays set.
- R7: After a fault, `ctl_enable` and `ctl_master` stay 0 until software writes them through `ctl_wr`.
- R8: With `sel_hw_ctrl`=1 and `sel_hold_cfg`=0 (per-frame policy), `sel_pin_o` goes to 0 after the edge that samples `frame_start`. It returns to 1 after the edge that samples `frame_end`, whatever `frame_more` holds.
- R9: With `sel_hw_ctrl`=1 and `sel_hold_cfg`=1 (held policy), a `frame_end` with `frame_more`=1 keeps `sel_pin_o` at 0. A `frame_end` with `frame_more`=0 returns it to 1.
- R10: With `sel_hw_ctrl`=0 and the pin driven, `sel_pin_o` equals `sw_sel_level` in the same cycle. Frame strobes have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | One-cycle strobe that loads the enable and master bits |
| ctl_wr_enable | input | 1 | Enable value written on `ctl_wr` |
| ctl_wr_master | input | 1 | Master-mode value written on `ctl_wr` (1 = master) |
| sel_oe_cfg | input | 1 | 1 = select pin is driven in master mode, 0 = select pin is an input |
| sel_hw_ctrl | input | 1 | 1 = select generated from frame strobes, 0 = select follows `sw_sel_level` |
| sel_hold_cfg | input | 1 | 1 = held policy across queued frames, 0 = per-frame policy |
| sw_sel_level | input | 1 | Software select level (0 = active) |
| frame_start | input | 1 | One-cycle strobe from the shift engine: a frame begins |
| frame_end | input | 1 | One-cycle strobe from the shift engine: a frame finished |
| frame_more | input | 1 | Another frame is queued, sampled with `frame_end` |
| fault_clr | input | 1 | Write-one-to-clear strobe for `fault_flag` |
| sel_pin_i | input | 1 | Select pin input value (asynchronous) |
| sel_pin_o | output | 1 | Select pin output value (active-low) |
| sel_pin_oe | output | 1 | Select pin output enable |
| ctl_enable | output | 1 | Controller enable state |
| ctl_master | output | 1 | Controller master-mode state |
| fault_flag | output | 1 | Sticky mode-fault flag |

## Verification
The assertions assume the frame strobes are single-cycle pulses and that `frame_start` and `frame_end` never coincide. They also assume the shift engine raises strobes only while the controller is driving select. The directed stimulus follows these rules: it raises each strobe for exactly one cycle, spaces them apart, and keeps the select input steady for at least three edges before each check. The fault scenarios hold the pin low long enough to pass the synchronizer. Those scenarios cover both the case where a clear coincides with a new fault and the case where no clear arrives.

// File: rtl/spisel_pkg.sv
package spisel_pkg;
  // Select pin polarity: asserted level is low
  localparam logic SEL_ASSERTED = 1'b0;
  localparam logic SEL_IDLE     = 1'b1;

  typedef enum logic {
    POL_PER_FRAME = 1'b0,
    POL_HELD      = 1'b1
  } sel_policy_e;
endpackage

// File: rtl/spisel_sync.sv
module spisel_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RESET_VAL;
        else        chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[LAST-1:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[LAST];
endmodule

// File: rtl/spisel_fault.sv
module spisel_fault
  import spisel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_wr_enable,
  input  logic ctl_wr_master,
  input  logic sel_oe_cfg,
  input  logic sel_sync,
  input  logic fault_clr,
  output logic en_q,
  output logic master_q,
  output logic fault_q
);
  logic fault_hit;

  // Three conditions together: master mode, pin as input, pin asserted
  assign fault_hit = master_q && !sel_oe_cfg && (sel_sync == SEL_ASSERTED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      master_q <= 1'b0;
    end else if (fault_hit) begin
      en_q     <= 1'b0;
      master_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q     <= ctl_wr_enable;
      master_q <= ctl_wr_master;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault_q <= 1'b0;
    else if (fault_hit) fault_q <= 1'b1;
    else if (fault_clr) fault_q <= 1'b0;
  end

  assert_fault_demotes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> (fault_q && !en_q && !master_q));

  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !fault_clr) |=> fault_q);

  assert_no_self_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctl_wr) |=> !en_q);

  assert_no_fault_when_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_q && (sel_oe_cfg || !master_q) && !$past(fault_hit)) |=> !fault_q);
endmodule

// File: rtl/spisel_frame.sv
module spisel_frame
  import spisel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        drive_en,
  input  logic        hw_ctrl,
  input  sel_policy_e policy,
  input  logic        sw_level,
  input  logic        frame_start,
  input  logic        frame_end,
  input  logic        frame_more,
  output logic        sel_level
);
  logic active_q;
  logic release_now;

  assign release_now = frame_end && ((policy == POL_PER_FRAME) || !frame_more);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                active_q <= 1'b0;
    else if (!drive_en || !hw_ctrl) active_q <= 1'b0;
    else if (frame_start)      active_q <= 1'b1;
    else if (release_now)      active_q <= 1'b0;
  end

  always_comb begin
    if (!drive_en)     sel_level = SEL_IDLE;
    else if (hw_ctrl)  sel_level = active_q ? SEL_ASSERTED : SEL_IDLE;
    else               sel_level = sw_level;
  end

  assert_perframe_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && hw_ctrl && policy == POL_PER_FRAME && frame_end && !frame_start)
      |=> !active_q);

  assert_held_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && hw_ctrl && policy == POL_HELD && active_q && frame_end && frame_more)
      |=> (active_q || !drive_en || !hw_ctrl));

  assert_sw_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && !hw_ctrl) |-> (sel_level == sw_level));
endmodule

// File: rtl/spisel_ctrl.sv
module spisel_ctrl
  import spisel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_wr_enable,
  input  logic ctl_wr_master,
  input  logic sel_oe_cfg,
  input  logic sel_hw_ctrl,
  input  logic sel_hold_cfg,
  input  logic sw_sel_level,
  input  logic frame_start,
  input  logic frame_end,
  input  logic frame_more,
  input  logic fault_clr,
  input  logic sel_pin_i,
  output logic sel_pin_o,
  output logic sel_pin_oe,
  output logic ctl_enable,
  output logic ctl_master,
  output logic fault_flag
);
  logic        sel_sync;
  logic        en_q, master_q, fault_q;
  logic        drive_en;
  sel_policy_e policy;

  spisel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(SEL_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sel_pin_i), .dout(sel_sync)
  );

  spisel_fault u_fault (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_wr_enable(ctl_wr_enable), .ctl_wr_master(ctl_wr_master),
    .sel_oe_cfg(sel_oe_cfg), .sel_sync(sel_sync), .fault_clr(fault_clr),
    .en_q(en_q), .master_q(master_q), .fault_q(fault_q)
  );

  // The pin is driven only by an enabled master configured to drive it
  assign drive_en = en_q && master_q && sel_oe_cfg;
  // Held policy exists only for a driven pin; drive_en already implies it
  assign policy   = (sel_hold_cfg && sel_oe_cfg) ? POL_HELD : POL_PER_FRAME;

  spisel_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .drive_en(drive_en), .hw_ctrl(sel_hw_ctrl), .policy(policy),
    .sw_level(sw_sel_level), .frame_start(frame_start), .frame_end(frame_end),
    .frame_more(frame_more), .sel_level(sel_pin_o)
  );

  assign sel_pin_oe = drive_en;
  assign ctl_enable = en_q;
  assign ctl_master = master_q;
  assign fault_flag = fault_q;

  assert_slave_releases_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_master |-> (!sel_pin_oe && sel_pin_o == SEL_IDLE));
endmodule

// File: tb/spisel_ctrl_test.sv
module spisel_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_wr_enable = 0, ctl_wr_master = 0;
  logic sel_oe_cfg = 0, sel_hw_ctrl = 1, sel_hold_cfg = 0, sw_sel_level = 1;
  logic frame_start = 0, frame_end = 0, frame_more = 0, fault_clr = 0;
  logic sel_pin_i = 1;
  logic sel_pin_o, sel_pin_oe, ctl_enable, ctl_master, fault_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  spisel_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wr_enable(ctl_wr_enable),
    .ctl_wr_master(ctl_wr_master), .sel_oe_cfg(sel_oe_cfg), .sel_hw_ctrl(sel_hw_ctrl),
    .sel_hold_cfg(sel_hold_cfg), .sw_sel_level(sw_sel_level), .frame_start(frame_start),
    .frame_end(frame_end), .frame_more(frame_more), .fault_clr(fault_clr),
    .sel_pin_i(sel_pin_i), .sel_pin_o(sel_pin_o), .sel_pin_oe(sel_pin_oe),
    .ctl_enable(ctl_enable), .ctl_master(ctl_master), .fault_flag(fault_flag)
  );

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctl(logic en, logic mst);
    ctl_wr = 1; ctl_wr_enable = en; ctl_wr_master = mst;
    step(1);
    ctl_wr = 0;
  endtask

  task automatic pulse_start();
    frame_start = 1; step(1); frame_start = 0;
  endtask

  task automatic pulse_end(logic more);
    frame_end = 1; frame_more = more; step(1); frame_end = 0; frame_more = 0;
  endtask

  task automatic clear_fault();
    fault_clr = 1; step(1); fault_clr = 0;
  endtask

  task automatic t_reset();
    check("R1", "enable", ctl_enable, 0);
    check("R1", "master", ctl_master, 0);
    check("R1", "fault", fault_flag, 0);
    check("R1", "oe", sel_pin_oe, 0);
    check("R1", "sel_o", sel_pin_o, 1);
  endtask

  task automatic t_write_and_slave();
    sel_oe_cfg = 1;
    write_ctl(1, 0);
    check("R2", "enable loaded", ctl_enable, 1);
    check("R2", "master loaded", ctl_master, 0);
    check("R5", "slave oe", sel_pin_oe, 0);
    check("R5", "slave sel_o", sel_pin_o, 1);
    sel_pin_i = 0; step(4);
    check("R4", "no fault as slave", fault_flag, 0);
    sel_pin_i = 1; step(3);
    write_ctl(1, 1);
    check("R5", "master driven oe", sel_pin_oe, 1);
    sel_pin_i = 0; step(4);
    check("R4", "no fault when driven", fault_flag, 0);
    check("R4", "master kept", ctl_master, 1);
    sel_pin_i = 1; step(3);
  endtask

  task automatic t_per_frame();
    sel_oe_cfg = 1; sel_hw_ctrl = 1; sel_hold_cfg = 0;
    check("R8", "idle before frame", sel_pin_o, 1);
    pulse_start();
    check("R8", "asserted after start", sel_pin_o, 0);
    step(2);
    pulse_end(1);
    check("R8", "released despite more", sel_pin_o, 1);
    pulse_start();
    pulse_end(0);
    check("R8", "released at last", sel_pin_o, 1);
  endtask

  task automatic t_held();
    sel_hold_cfg = 1;
    pulse_start();
    check("R9", "asserted after start", sel_pin_o, 0);
    pulse_end(1);
    check("R9", "held over queued frame", sel_pin_o, 0);
    pulse_start();
    pulse_end(1);
    check("R9", "still held", sel_pin_o, 0);
    pulse_start();
    pulse_end(0);
    check("R9", "released after last", sel_pin_o, 1);
    sel_hold_cfg = 0;
  endtask

  task automatic t_software();
    sel_hw_ctrl = 0; sw_sel_level = 1;
    step(1);
    check("R10", "sw high", sel_pin_o, 1);
    sw_sel_level = 0; #1;
    check("R10", "sw low same cycle", sel_pin_o, 0);
    pulse_end(0);
    check("R10", "end strobe ignored", sel_pin_o, 0);
    sw_sel_level = 1; sel_hw_ctrl = 1;
    step(1);
  endtask

  task automatic t_fault();
    sel_oe_cfg = 0;
    step(1);
    check("R5", "input mode oe", sel_pin_oe, 0);
    sel_pin_i = 0;
    step(2);
    check("R3", "enable before latency", ctl_enable, 1);
    check("R3", "fault before latency", fault_flag, 0);
    step(1);
    check("R3", "fault set", fault_flag, 1);
    check("R3", "enable cleared", ctl_enable, 0);
    check("R3", "demoted", ctl_master, 0);
    check("R3", "oe cleared", sel_pin_oe, 0);
    sel_pin_i = 1;
    step(5);
    check("R6", "sticky", fault_flag, 1);
    check("R7", "no self enable", ctl_enable, 0);
    check("R7", "no self master", ctl_master, 0);
    clear_fault();
    check("R6", "cleared", fault_flag, 0);
  endtask

  task automatic t_clear_collision();
    write_ctl(1, 1);
    sel_pin_i = 0;
    step(2);
    fault_clr = 1; step(1); fault_clr = 0;
    check("R6", "set wins over clear", fault_flag, 1);
    sel_pin_i = 1; step(3);
    write_ctl(1, 1);
    check("R7", "software re-enable", ctl_enable, 1);
    check("R7", "software re-master", ctl_master, 1);
    clear_fault();
    check("R6", "clear after collision", fault_flag, 0);
  endtask

  initial begin
    step(2);
    t_reset();
    rst_n = 1;
    step(1);
    t_reset();
    t_write_and_slave();
    t_per_frame();
    t_held();
    t_software();
    t_fault();
    t_clear_collision();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule